// File: doc/BRIEF.md
# Packed Integer-to-Float Converter

This unit takes a 64-bit operand that holds two signed 32-bit integers and turns each into an IEEE-754 single-precision value. A 2-bit rounding-control input picks how inexact results are rounded. The two floats are written into the lower 64 bits of a 128-bit register image. The upper 64 bits of the incoming image pass through unchanged. An inexact flag is the OR, over both lanes, of whether any bit was lost in rounding.

Every completed conversion also switches the legacy floating-point stack into packed-integer mode. The stack-top output is driven to zero and every tag-word bit to zero, which means all entries are valid. When no conversion completes in a cycle, the stack-top and tag outputs follow their inputs one cycle late.

A start request that arrives while a legacy floating-point exception is pending is not converted. The operands are captured, a blocked indication is raised, and the conversion runs as soon as the pending flag is seen low.

Top module: `pk_i2f_unit`

## Requirements
- R1: Source bits 31:0 convert into destination bits 31:0, and source bits 63:32 convert into destination bits 63:32. Each lane is an IEEE-754 single-precision word laid out as {sign, 8-bit exponent with bias 127, 23-bit fraction}.
- R2: Destination output bits 127:64 equal bits 127:64 of the old destination image supplied with the accepted request.
- R3: The rounding-control encoding is 00 = nearest with ties to even, 01 = toward negative infinity, 10 = toward positive infinity, 11 = toward zero. It is applied to any lane magnitude wider than 24 significant bits.
- R4: The inexact output is 1 in a done cycle exactly when either lane dropped a non-zero bit. It is never 1 when both lanes are exact, which includes every magnitude below 2^24.
- R5: An input of 0 gives 0x00000000, and an input of -2^31 gives 0xCF000000 (sign 1, exponent 158, fraction 0).
- R6: A start accepted with no exception pending and no blocked request gives done high for exactly the cycle after the sampling edge, with all results valid in that cycle. A start on every cycle gives a done on every cycle.
- R7: In a done cycle the stack-top output is 0 and the tag output is all zeros. In any other cycle after reset, each equals the value its input had at the previous edge.
- R8: A start sampled while the exception-pending input is 1 produces no done. Blocked is high from the next cycle on, and the stack-top and tag outputs keep following their inputs. At the first edge where the pending input is 0, the captured operands and rounding mode are converted, done pulses and blocked falls.
- R9: A start that arrives while blocked is high is ignored: it produces no done and does not replace the captured operands.
- R10: A synchronous reset clears done, blocked, stack-top and tag outputs.
- R11: When rounding carries out of the 24-bit significand, the exponent goes up by one and the fraction becomes zero. For example, 0x01FFFFFF rounded toward positive infinity gives 0x4C000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Conversion request, sampled on the rising edge |
| exc_pend_i | input | 1 | Legacy floating-point exception pending |
| src_i | input | 64 | Two packed signed 32-bit integers |
| dst_i | input | 128 | Old destination register image |
| rmode_i | input | 2 | Rounding-control field |
| fpu_top_i | input | 3 | Current legacy stack-top pointer |
| fpu_tag_i | input | 16 | Current legacy tag word |
| dst_o | output | 128 | New destination image |
| inexact_o | output | 1 | Result rounded in at least one lane |
| top_o | output | 3 | Updated stack-top pointer |
| tag_o | output | 16 | Updated tag word |
| done_o | output | 1 | One-cycle result-valid pulse |
| blocked_o | output | 1 | Request held until the exception is serviced |

## Verification
Each lane is compared against a reference conversion under all four rounding modes.

- Powers of two and small magnitudes are exact, so they show whether normalisation and the exponent are right apart from any rounding.
- Values just above 2^24 and near 2^31 have guard and sticky bits set in different combinations. They separate ties-to-even from the directed modes, and they expose a missing exponent increment on rounding carry.
- Zero, -1, -2^31 and random signed values check the sign and magnitude path and lane placement.
- A held request with a second start issued during the hold shows whether captured operands are preserved, and whether the legacy-stack outputs keep passing through until the deferred conversion fires.

// File: rtl/pk_i2f_pkg.sv
package pk_i2f_pkg;
    localparam int IW   = 32;          // integer lane width
    localparam int FW   = 32;          // float word width
    localparam int EW   = 8;           // exponent width
    localparam int SIGW = 24;          // significand incl. hidden bit
    localparam int BIAS = 127;
    localparam int LZW  = $clog2(IW);

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_DOWN    = 2'b01,
        RM_UP      = 2'b10,
        RM_ZERO    = 2'b11
    } rmode_e;
endpackage

// File: rtl/i2f_lzc.sv
module i2f_lzc #(
    parameter int W   = 32,
    localparam int CW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic [CW-1:0] cnt_o
);
    // highest set bit wins; all-zero input yields W-1
    always_comb begin
        cnt_o = CW'(W - 1);
        for (int i = 0; i < W; i++) begin
            if (vec_i[i]) cnt_o = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/i2f_lane.sv
module i2f_lane
    import pk_i2f_pkg::*;
(
    input  logic [IW-1:0] int_i,
    input  rmode_e        rm_i,
    output logic [FW-1:0] flt_o,
    output logic          inexact_o
);
    logic            sign_w;
    logic [IW-1:0]   mag_w;
    logic [LZW-1:0]  lz_w;
    logic [IW-1:0]   norm_w;
    logic            guard_w;
    logic            sticky_w;
    logic            inc_w;
    logic [SIGW:0]   sum_w;
    logic            nz_w;
    logic [EW:0]     exp_w;
    logic [SIGW-2:0] frac_w;

    assign sign_w = int_i[IW-1];
    assign mag_w  = sign_w ? (~int_i + IW'(1)) : int_i;

    i2f_lzc #(.W(IW)) u_lzc (
        .vec_i (mag_w),
        .cnt_o (lz_w)
    );

    always_comb begin
        norm_w   = mag_w << lz_w;
        guard_w  = norm_w[IW-1-SIGW];
        sticky_w = |norm_w[IW-2-SIGW:0];
        unique case (rm_i)
            RM_NEAREST: inc_w = guard_w & (sticky_w | norm_w[IW-SIGW]);
            RM_DOWN:    inc_w = sign_w & (guard_w | sticky_w);
            RM_UP:      inc_w = ~sign_w & (guard_w | sticky_w);
            default:    inc_w = 1'b0;
        endcase
        sum_w  = {1'b0, norm_w[IW-1 -: SIGW]} + (SIGW+1)'(inc_w);
        nz_w   = sum_w[SIGW] | sum_w[SIGW-1];
        exp_w  = (EW+1)'(BIAS + IW - 1) - (EW+1)'(lz_w) + (EW+1)'(sum_w[SIGW]);
        frac_w = sum_w[SIGW] ? '0 : sum_w[SIGW-2:0];
        if (nz_w) begin
            flt_o     = {sign_w, exp_w[EW-1:0], frac_w};
            inexact_o = guard_w | sticky_w;
        end else begin
            flt_o     = '0;
            inexact_o = 1'b0;
        end
    end

    always_comb begin
        if (mag_w < IW'(1 << SIGW)) begin
            AST_SMALL_EXACT: assert (!inexact_o); // R4
        end
    end
endmodule

// File: rtl/pk_i2f_unit.sv
module pk_i2f_unit
    import pk_i2f_pkg::*;
#(
    parameter int LANES = 2,
    parameter int TOPW  = 3,
    parameter int TAGW  = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic                    exc_pend_i,
    input  logic [LANES*IW-1:0]     src_i,
    input  logic [2*LANES*IW-1:0]   dst_i,
    input  logic [1:0]              rmode_i,
    input  logic [TOPW-1:0]         fpu_top_i,
    input  logic [TAGW-1:0]         fpu_tag_i,
    output logic [2*LANES*IW-1:0]   dst_o,
    output logic                    inexact_o,
    output logic [TOPW-1:0]         top_o,
    output logic [TAGW-1:0]         tag_o,
    output logic                    done_o,
    output logic                    blocked_o
);
    localparam int SW = LANES * IW;
    localparam int DW = 2 * SW;
    localparam logic [DW-1:0] LOW_MASK = {{(DW-SW){1'b0}}, {SW{1'b1}}};

    typedef struct packed {
        logic            done;
        logic            blocked;
        logic [SW-1:0]   src_h;
        logic [DW-1:0]   dst_h;
        logic [1:0]      rm_h;
        logic [DW-1:0]   res;
        logic            inexact;
        logic [TOPW-1:0] top;
        logic [TAGW-1:0] tag;
    } st_t;

    st_t st_d, st_q;

    logic [SW-1:0]    src_sel;
    logic [DW-1:0]    dst_sel;
    logic [1:0]       rm_sel;
    logic [SW-1:0]    lane_res;
    logic [LANES-1:0] lane_inx;

    // a held request always takes priority over the live operands
    assign src_sel = st_q.blocked ? st_q.src_h : src_i;
    assign dst_sel = st_q.blocked ? st_q.dst_h : dst_i;
    assign rm_sel  = st_q.blocked ? st_q.rm_h  : rmode_i;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        i2f_lane u_lane (
            .int_i     (src_sel[g*IW +: IW]),
            .rm_i      (rmode_e'(rm_sel)),
            .flt_o     (lane_res[g*FW +: FW]),
            .inexact_o (lane_inx[g])
        );
    end

    always_comb begin
        logic accept_w;
        logic fire_w;
        st_d      = st_q;
        st_d.done = 1'b0;
        accept_w  = start_i && !st_q.blocked;
        fire_w    = !exc_pend_i && (accept_w || st_q.blocked);

        if (accept_w && exc_pend_i) begin
            st_d.blocked = 1'b1;
            st_d.src_h   = src_i;
            st_d.dst_h   = dst_i;
            st_d.rm_h    = rmode_i;
        end

        if (fire_w) begin
            st_d.done    = 1'b1;
            st_d.blocked = 1'b0;
            st_d.res     = (dst_sel & ~LOW_MASK) | {{(DW-SW){1'b0}}, lane_res};
            st_d.inexact = |lane_inx;
            st_d.top     = '0;
            st_d.tag     = '0;
        end else begin
            st_d.top     = fpu_top_i;
            st_d.tag     = fpu_tag_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dst_o     = st_q.res;
    assign inexact_o = st_q.inexact;
    assign top_o     = st_q.top;
    assign tag_o     = st_q.tag;
    assign done_o    = st_q.done;
    assign blocked_o = st_q.blocked;

    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
        (start_i && !exc_pend_i && !blocked_o) |=> (done_o && dst_o[DW-1:SW] == $past(dst_i[DW-1:SW]))); // R2
    AST_STACK_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (start_i && !exc_pend_i && !blocked_o) |=> (top_o == '0 && tag_o == '0)); // R7
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
        (start_i && exc_pend_i && !blocked_o) |=> (blocked_o && !done_o)); // R8
    AST_PEND_WAIT: assert property (@(posedge clk) disable iff (rst)
        (blocked_o && exc_pend_i) |=> (blocked_o && !done_o)); // R9
    AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (blocked_o && !exc_pend_i) |=> (done_o && !blocked_o)); // R8
endmodule

// File: tb/sim_pk_i2f_unit.sv
`timescale 1ns/1ps
module sim_pk_i2f_unit;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic         exc_pend_i = 1'b0;
    logic [63:0]  src_i = '0;
    logic [127:0] dst_i = '0;
    logic [1:0]   rmode_i = '0;
    logic [2:0]   fpu_top_i = '0;
    logic [15:0]  fpu_tag_i = '0;
    logic [127:0] dst_o;
    logic         inexact_o;
    logic [2:0]   top_o;
    logic [15:0]  tag_o;
    logic         done_o;
    logic         blocked_o;

    always #2 clk = ~clk;

    pk_i2f_unit u0 (.*);

    typedef struct {
        logic [127:0] dst;
        logic         inx;
        string        req;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   ended = 0;

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_cvt(input logic [31:0] x, input logic [1:0] rm, output logic inx);
        logic        s;
        logic [63:0] m, q, r, half;
        int          p, sh, e;
        logic        up;
        s   = x[31];
        m   = s ? (64'h1_0000_0000 - {32'b0, x}) : {32'b0, x};
        inx = 1'b0;
        if (m == 0) return 32'h0;
        p = 0;
        for (int i = 0; i < 64; i++) if (m[i]) p = i;
        if (p <= 23) return {s, 8'(127 + p), 23'(m << (23 - p))};
        sh   = p - 23;
        q    = m >> sh;
        r    = m - (q << sh);
        half = 64'd1 << (sh - 1);
        inx  = (r != 0);
        case (rm)
            2'b00:   up = (r > half) || (r == half && q[0]);
            2'b01:   up = s && (r != 0);
            2'b10:   up = !s && (r != 0);
            default: up = 1'b0;
        endcase
        q = q + 64'(up);
        e = 127 + p;
        if (q == (64'd1 << 24)) begin
            q = q >> 1;
            e++;
        end
        return {s, 8'(e), q[22:0]};
    endfunction

    // driver: called at posedge+1, returns at next posedge+1
    task automatic issue(input logic [31:0] lo, input logic [31:0] hi, input logic [1:0] rm,
                         input logic [127:0] old, input string req, input bit push);
        exp_t it;
        logic i0, i1;
        it.dst = {old[127:64], ref_cvt(hi, rm, i1), ref_cvt(lo, rm, i0)};
        it.inx = i0 | i1;
        it.req = req;
        if (push) sb_q.push_back(it);
        start_i = 1'b1;
        src_i   = {hi, lo};
        dst_i   = old;
        rmode_i = rm;
        @(posedge clk); #1;
        start_i = 1'b0;
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && !ended && done_o) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R9 unexpected done", {127'b0, done_o}, 128'h0);
            end else begin
                exp_t it;
                it = sb_q.pop_front();
                chk(dst_o[31:0] == it.dst[31:0], {it.req, " R1 low lane"}, {96'b0, dst_o[31:0]}, {96'b0, it.dst[31:0]});
                chk(dst_o[63:32] == it.dst[63:32], {it.req, " R1 high lane"}, {96'b0, dst_o[63:32]}, {96'b0, it.dst[63:32]});
                chk(dst_o[127:64] == it.dst[127:64], "R2 upper half", dst_o, it.dst);
                chk(inexact_o == it.inx, "R4 inexact", {127'b0, inexact_o}, {127'b0, it.inx});
                chk(top_o == 3'd0 && tag_o == 16'd0, "R7 stack cleared", {109'b0, top_o, tag_o}, 128'h0);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] specials [12];
        specials = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h0100_0000, 32'h0100_0001, 32'h0100_0003,
                     32'h7FFF_FFFF, 32'h8000_0000, 32'h8000_0001, 32'h01FF_FFFF, 32'hFEFF_FFFF, 32'h0300_0002};
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        chk(done_o == 0 && blocked_o == 0, "R10 reset done/blocked", {126'b0, done_o, blocked_o}, 128'h0);
        chk(top_o == 0 && tag_o == 0, "R10 reset stack", {109'b0, top_o, tag_o}, 128'h0);
        rst = 1'b0;
        @(posedge clk); #1;

        // R7: pass-through while idle
        fpu_top_i = 3'd5;
        fpu_tag_i = 16'hABCD;
        @(posedge clk); @(negedge clk);
        chk(top_o == 3'd5 && tag_o == 16'hABCD, "R7 idle pass-through", {109'b0, top_o, tag_o}, {109'b0, 3'd5, 16'hABCD});
        @(posedge clk); #1;

        // R5 fixed values
        issue(32'h0, 32'h8000_0000, 2'b00, rnd128(), "R5", 1);
        @(posedge clk); #1;
        chk(dst_o[63:0] == 64'hCF00_0000_0000_0000, "R5 zero and -2^31", {64'b0, dst_o[63:0]}, {64'b0, 64'hCF00_0000_0000_0000});
        // R11 carry case
        issue(32'h01FF_FFFF, 32'h0100_0001, 2'b10, rnd128(), "R11", 1);
        @(posedge clk); #1;
        chk(dst_o[31:0] == 32'h4C00_0000, "R11 carry exponent", {96'b0, dst_o[31:0]}, {96'b0, 32'h4C00_0000});

        // R3: specials under all modes, back to back (R6)
        for (int m = 0; m < 4; m++) begin
            for (int i = 0; i < 12; i++) begin
                issue(specials[i], specials[(i + 5) % 12], 2'(m), rnd128(), "R3 special", 1);
            end
        end
        // powers of two, both signs
        for (int k = 0; k < 31; k++) begin
            issue(32'd1 << k, -(32'd1 << k), 2'(k % 4), rnd128(), "R1 power of two", 1);
        end
        // near 2^24 and 2^31
        for (int d = -4; d <= 4; d++) begin
            for (int m = 0; m < 4; m++) begin
                issue(32'h0100_0000 + 32'(d), 32'h7FFF_FF00 + 32'(d * 37), 2'(m), rnd128(), "R3 near limit", 1);
            end
        end
        // random
        for (int n = 0; n < 300; n++) begin
            logic [31:0] a, b;
            a = $urandom;
            b = $urandom >> ($urandom % 32);
            if ($urandom % 2) b = -b;
            issue(a, b, 2'($urandom % 4), rnd128(), "R3 random", 1);
        end
        @(posedge clk); #1;
        // R6: single pulse
        @(negedge clk);
        chk(done_o == 0, "R6 done single pulse", {127'b0, done_o}, 128'h0);
        @(posedge clk); #1;

        // R8 / R9: held request
        fpu_top_i  = 3'd6;
        fpu_tag_i  = 16'h5A5A;
        exc_pend_i = 1'b1;
        issue(32'h0100_0001, 32'hFFFF_FFFD, 2'b10, 128'h1234_5678_9ABC_DEF0_0F0F_0F0F_F0F0_F0F0, "R8 held", 1);
        chk(blocked_o == 1 && done_o == 0, "R8 blocked after start", {126'b0, blocked_o, done_o}, {126'b0, 2'b10});
        issue(32'h7FFF_FFFF, 32'h1, 2'b00, 128'h0, "R9 ignored", 0);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk(done_o == 0 && blocked_o == 1, "R8 no done while pending", {126'b0, blocked_o, done_o}, {126'b0, 2'b10});
            chk(top_o == 3'd6 && tag_o == 16'h5A5A, "R8 stack pass-through", {109'b0, top_o, tag_o}, {109'b0, 3'd6, 16'h5A5A});
            @(posedge clk); #1;
        end
        exc_pend_i = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(done_o == 1 && blocked_o == 0, "R8 release", {126'b0, blocked_o, done_o}, {126'b0, 2'b01});
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(blocked_o == 0 && done_o == 0, "R9 no extra work", {126'b0, blocked_o, done_o}, 128'h0);
        chk(sb_q.size() == 0, "R6 every request completed", 128'(sb_q.size()), 128'h0);

        ended = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule